// File: doc/BRIEF.md
# Stack-Pointer Immediate Builder with Prefix Extension

This unit watches a stream of 16-bit instruction words, at most one per clock, qualified by a valid strobe. It recognises two kinds of word. An extension prefix carries a payload in its low 13 bits. A stack-pointer load carries a 7-bit immediate in its low 7 bits. The unit keeps up to two prefix payloads waiting. When a load arrives, it joins the waiting payloads with the load's own 7 bits into an operand that is 7, 20 or 24 bits wide. It then writes that operand into a 24-bit stack-pointer register, with the lowest two bits always cleared.

A side input marks a word that executes in a branch delay slot. A load marked this way ignores any waiting payloads and acts as the bare 7-bit form. Once any non-prefix word is consumed, the waiting payloads are dropped, so no extension carries over to a later instruction. The load completes in one cycle, and no condition flags are touched.

Top module: `sp_imm_ext`

## Requirements
- R1: A valid word whose bits 15:7 are 101111000 is a stack-pointer load, and its bits 6:0 form imm7. No other valid word writes the stack pointer.
- R2: A load with nothing waiting writes SP = {17'b0, imm7[6:2], 2'b00}.
- R3: A load after one waiting prefix with payload P writes SP = {4'b0, P[12:0], imm7[6:2], 2'b00}. For example, P = 0x8 and imm7 = 0 give SP = 0x400.
- R4: A load after two consecutive prefixes writes SP = {F[3:0], S[12:0], imm7[6:2], 2'b00}, where F is the first payload and S is the second.
- R5: Bits 1:0 of the stack pointer are always zero.
- R6: The write strobe sp_wr is high for exactly the one cycle after a load is accepted, and the new SP value is visible in that same cycle. SP holds its value when no write takes place.
- R7: A load accepted while in_delay_slot is high behaves as R2, whatever payloads are waiting.
- R8: Any valid non-prefix word, whether a load or not, discards all waiting payloads.
- R9: A prefix is a valid word whose bits 15:13 equal the parameter PFX_OPC (default 110), and its payload is bits 12:0. After three or more prefixes in a row, the two most recent ones count as first and second.
- R10: A word presented while insn_valid is low has no effect, and waiting payloads are kept.
- R11: A synchronous active-high reset sets SP to zero, sets sp_wr low and discards waiting payloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word strobe |
| insn_word | input | 16 | Instruction word |
| in_delay_slot | input | 1 | Word executes in a branch delay slot |
| sp_value | output | 24 | Stack-pointer register |
| sp_wr | output | 1 | One-cycle pulse when SP was written |

## Verification
When a load is accepted, two things happen at the same edge. The waiting payloads are used to build SP, and they are also cleared. The bench stacks two prefixes before a load to test this. It then sends a bare load right away and expects a 7-bit-only result. A leftover payload would show up in bits 23:7. A second case sets the delay-slot flag on the load while payloads are waiting. Here the override and the clearing happen together. The bench checks that both that load and the bare load after it leave the upper bits clear.

// File: rtl/sp_ext_pkg.sv
package sp_ext_pkg;
    localparam int SP_W   = 24;
    localparam int WORD_W = 16;
    localparam int IMM7_W = 7;
    localparam int MID_W  = 13;
    localparam int HI_W   = 4;
    localparam int OPC_W  = WORD_W - IMM7_W;
    localparam logic [OPC_W-1:0] LDSP_OPC = 9'b1_0111_1000;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_ONE  = 2'd1,
        PEND_TWO  = 2'd2
    } pend_e;

    typedef struct packed {
        pend_e             pend;
        logic [HI_W-1:0]   hi;
        logic [MID_W-1:0]  mid;
        logic [SP_W-1:0]   sp;
        logic              wr;
    } ext_state_t;
endpackage

// File: rtl/sp_ext_decode.sv
module sp_ext_decode
    import sp_ext_pkg::*;
#(
    parameter int                   PFX_OPC_W = 3,
    parameter logic [PFX_OPC_W-1:0] PFX_OPC   = 3'b110
) (
    input  logic                 valid,
    input  logic [WORD_W-1:0]    word,
    output logic                 is_pfx,
    output logic                 is_ld,
    output logic                 is_other,
    output logic [MID_W-1:0]     payload,
    output logic [IMM7_W-1:0]    imm7
);
    always_comb begin
        is_pfx   = valid && (word[WORD_W-1 -: PFX_OPC_W] == PFX_OPC);
        is_ld    = valid && !is_pfx && (word[WORD_W-1 -: OPC_W] == LDSP_OPC);
        is_other = valid && !is_pfx && !is_ld;
        payload  = word[MID_W-1:0];
        imm7     = word[IMM7_W-1:0];
    end
endmodule

// File: rtl/sp_ext_compose.sv
module sp_ext_compose
    import sp_ext_pkg::*;
#(
    parameter int ALIGN_BITS = 2
) (
    input  pend_e              pend,
    input  logic               dslot,
    input  logic [HI_W-1:0]    hi,
    input  logic [MID_W-1:0]   mid,
    input  logic [IMM7_W-1:0]  imm7,
    output logic [SP_W-1:0]    sp_new
);
    localparam int PAD20 = SP_W - MID_W - IMM7_W;
    localparam int PAD7  = SP_W - IMM7_W;

    pend_e            eff;
    logic [SP_W-1:0]  raw;

    always_comb begin
        eff = dslot ? PEND_NONE : pend;
        case (eff)
            PEND_ONE: raw = {{PAD20{1'b0}}, mid, imm7};
            PEND_TWO: raw = {hi, mid, imm7};
            default:  raw = {{PAD7{1'b0}}, imm7};
        endcase
    end

    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign sp_new = {raw[SP_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end else begin : g_noalign
            assign sp_new = raw;
        end
    endgenerate
endmodule

// File: rtl/sp_imm_ext.sv
module sp_imm_ext
    import sp_ext_pkg::*;
#(
    parameter int                   PFX_OPC_W = 3,
    parameter logic [PFX_OPC_W-1:0] PFX_OPC   = 3'b110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_valid,
    input  logic [15:0]       insn_word,
    input  logic              in_delay_slot,
    output logic [23:0]       sp_value,
    output logic              sp_wr
);
    ext_state_t state_d, state_q;

    logic               is_pfx, is_ld, is_other;
    logic [MID_W-1:0]   payload;
    logic [IMM7_W-1:0]  imm7;
    logic [SP_W-1:0]    sp_new;
    logic [1:0]         pend_level;

    sp_ext_decode #(
        .PFX_OPC_W (PFX_OPC_W),
        .PFX_OPC   (PFX_OPC)
    ) u_decode (
        .valid    (insn_valid),
        .word     (insn_word),
        .is_pfx   (is_pfx),
        .is_ld    (is_ld),
        .is_other (is_other),
        .payload  (payload),
        .imm7     (imm7)
    );

    sp_ext_compose #(
        .ALIGN_BITS (2)
    ) u_compose (
        .pend   (state_q.pend),
        .dslot  (in_delay_slot),
        .hi     (state_q.hi),
        .mid    (state_q.mid),
        .imm7   (imm7),
        .sp_new (sp_new)
    );

    always_comb begin
        state_d    = state_q;
        state_d.wr = 1'b0;
        if (is_pfx) begin
            if (state_q.pend == PEND_NONE) begin
                state_d.pend = PEND_ONE;
            end else begin
                state_d.pend = PEND_TWO;
                state_d.hi   = state_q.mid[HI_W-1:0];
            end
            state_d.mid = payload;
        end else if (is_ld || is_other) begin
            state_d.pend = PEND_NONE;
            state_d.hi   = '0;
            state_d.mid  = '0;
            if (is_ld) begin
                state_d.sp = sp_new;
                state_d.wr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sp_value   = state_q.sp;
    assign sp_wr      = state_q.wr;
    assign pend_level = state_q.pend;
endmodule

// File: rtl/sp_ext_chk.sv
module sp_ext_chk
    import sp_ext_pkg::*;
#(
    parameter int                   PFX_OPC_W = 3,
    parameter logic [PFX_OPC_W-1:0] PFX_OPC   = 3'b110
) (
    input logic              clk,
    input logic              rst,
    input logic              insn_valid,
    input logic [15:7]       insn_hi,
    input logic              in_delay_slot,
    input logic [23:0]       sp_value,
    input logic              sp_wr,
    input logic [1:0]        pend_level
);
    logic was_pfx_in;
    logic was_ld_in;
    assign was_pfx_in = insn_valid && (insn_hi[15 -: PFX_OPC_W] == PFX_OPC);
    assign was_ld_in  = insn_valid && (insn_hi == LDSP_OPC) && !was_pfx_in;

    // R6
    load_gives_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(was_ld_in)) |-> sp_wr);

    // R1
    strobe_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
        sp_wr |-> $past(was_ld_in));

    // R5
    low_bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sp_value[1:0] == 2'b00);

    // R6
    sp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !sp_wr) |-> $stable(sp_value));

    // R7
    dslot_narrow_chk: assert property (@(posedge clk) disable iff (rst)
        (sp_wr && $past(in_delay_slot)) |-> (sp_value[23:7] == '0));

    // R8
    pend_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(insn_valid) && !$past(was_pfx_in)) |-> (pend_level == 2'd0));

    // R11
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sp_value == '0 && !sp_wr && pend_level == 2'd0));
endmodule

bind sp_imm_ext sp_ext_chk #(
    .PFX_OPC_W (PFX_OPC_W),
    .PFX_OPC   (PFX_OPC)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .insn_valid    (insn_valid),
    .insn_hi       (insn_word[15:7]),
    .in_delay_slot (in_delay_slot),
    .sp_value      (sp_value),
    .sp_wr         (sp_wr),
    .pend_level    (pend_level)
);

// File: tb/sp_imm_ext_test.sv
module sp_imm_ext_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid = 1'b0;
    logic [15:0] insn_word = 16'h0;
    logic        in_delay_slot = 1'b0;
    logic [23:0] sp_value;
    logic        sp_wr;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sp_imm_ext uut (
        .clk           (clk),
        .rst           (rst),
        .insn_valid    (insn_valid),
        .insn_word     (insn_word),
        .in_delay_slot (in_delay_slot),
        .sp_value      (sp_value),
        .sp_wr         (sp_wr)
    );

    function automatic logic [15:0] ld(input logic [6:0] i7);
        return {9'b1_0111_1000, i7};
    endfunction

    function automatic logic [15:0] pfx(input logic [12:0] p);
        return {3'b110, p};
    endfunction

    function automatic logic [23:0] align(input logic [23:0] v);
        return {v[23:2], 2'b00};
    endfunction

    task automatic check(input string req, input logic [23:0] exp_sp, input logic exp_wr);
        n_chk++;
        if (sp_value !== exp_sp || sp_wr !== exp_wr) begin
            n_fail++;
            $display("FAIL %s: sp=%h wr=%b expected sp=%h wr=%b", req, sp_value, sp_wr, exp_sp, exp_wr);
        end
    endtask

    // drive one word at a falling edge; outputs are sampled at the next falling edge
    task automatic put(input logic [15:0] w, input logic ds, input logic v);
        insn_word     = w;
        in_delay_slot = ds;
        insn_valid    = v;
        @(negedge clk);
        insn_valid    = 1'b0;
        in_delay_slot = 1'b0;
    endtask

    task automatic t_reset;
        check("R11", 24'h0, 1'b0);
    endtask

    task automatic t_plain;
        put(ld(7'h7F), 1'b0, 1'b1);
        check("R2", 24'h00007C, 1'b1);
        put(16'h0, 1'b0, 1'b0);
        check("R6", 24'h00007C, 1'b0);
        put(ld(7'h13), 1'b0, 1'b1);
        check("R5", 24'h000010, 1'b1);
    endtask

    task automatic t_one_prefix;
        put(pfx(13'h0008), 1'b0, 1'b1);
        put(ld(7'h00), 1'b0, 1'b1);
        check("R3", 24'h000400, 1'b1);
        put(pfx(13'h1ABC), 1'b0, 1'b1);
        put(ld(7'h55), 1'b0, 1'b1);
        check("R3", align({4'h0, 13'h1ABC, 7'h55}), 1'b1);
    endtask

    task automatic t_two_prefix;
        put(pfx(13'h0005), 1'b0, 1'b1);
        put(pfx(13'h1234), 1'b0, 1'b1);
        put(ld(7'h3F), 1'b0, 1'b1);
        check("R4", align({4'h5, 13'h1234, 7'h3F}), 1'b1);
        // load consumed the prefixes: a bare load right after is narrow
        put(ld(7'h21), 1'b0, 1'b1);
        check("R8", 24'h000020, 1'b1);
    endtask

    task automatic t_three_prefix;
        put(pfx(13'h000A), 1'b0, 1'b1);
        put(pfx(13'h0003), 1'b0, 1'b1);
        put(pfx(13'h0F0F), 1'b0, 1'b1);
        put(ld(7'h01), 1'b0, 1'b1);
        check("R9", align({4'h3, 13'h0F0F, 7'h01}), 1'b1);
    endtask

    task automatic t_delay_slot;
        put(pfx(13'h000F), 1'b0, 1'b1);
        put(pfx(13'h1FFF), 1'b0, 1'b1);
        put(ld(7'h6B), 1'b1, 1'b1);
        check("R7", 24'h000068, 1'b1);
        put(ld(7'h00), 1'b0, 1'b1);
        check("R8", 24'h000000, 1'b1);
    endtask

    task automatic t_other_word;
        put(ld(7'h08), 1'b0, 1'b1);
        check("R2", 24'h000008, 1'b1);
        put(pfx(13'h0100), 1'b0, 1'b1);
        put(16'h0000, 1'b0, 1'b1);
        check("R1", 24'h000008, 1'b0);
        // bits 15:7 = 101111001: not a load
        put(16'hBC80 | 16'h0010, 1'b0, 1'b1);
        check("R1", 24'h000008, 1'b0);
        put(ld(7'h10), 1'b0, 1'b1);
        check("R8", 24'h000010, 1'b1);
    endtask

    task automatic t_invalid;
        put(pfx(13'h0002), 1'b0, 1'b1);
        put(ld(7'h7C), 1'b0, 1'b0);
        check("R10", 24'h000010, 1'b0);
        put(16'h0000, 1'b0, 1'b0);
        check("R10", 24'h000010, 1'b0);
        put(ld(7'h04), 1'b0, 1'b1);
        check("R10", align({4'h0, 13'h0002, 7'h04}), 1'b1);
    endtask

    task automatic t_mid_reset;
        put(pfx(13'h1000), 1'b0, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R11", 24'h0, 1'b0);
        rst = 1'b0;
        put(ld(7'h0C), 1'b0, 1'b1);
        check("R11", 24'h00000C, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_one_prefix();
        t_two_prefix();
        t_three_prefix();
        t_delay_slot();
        t_other_word();
        t_invalid();
        t_mid_reset();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule